// File: doc/BRIEF.md
# Address-Space-Tagged Set-Associative Translation Buffer

This block translates virtual addresses to physical addresses for one access side of a processor, either instruction fetch or data load/store. The side is chosen by a parameter. It is built from several ways. Each way has its own page size and a small number of entries. Each entry holds a virtual page tag, a physical page base, an 8-bit address-space identifier (ASID) and a 4-bit attribute code. An entry whose ASID is zero is empty. A 32-bit ring map register holds four ASIDs, one byte for each privilege ring. An entry can only match when its ASID appears in that map, and the position of the matching byte gives the entry's ring.

A lookup request carries a virtual address, an access kind and the current privilege ring. The block answers one cycle after it accepts the request. The answer carries a fault cause code. When the lookup succeeds it also carries the translated address. When exactly one way hits it also carries the decoded permissions, the cache mode and the ring.

Entries are loaded in two ways. A direct write port names the target way. A refill port takes a page-table entry and places it in one of ways 0..3, chosen in rotation. The block also reports, for each lookup, the address of the page-table entry that a walker would fetch for that virtual address. The walker itself lives outside the block.

Lookups use a valid/ready handshake on both sides. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is held, or the held response is being taken in the same cycle. A response stays on the outputs, unchanged, until a clock edge where `rsp_valid` and `rsp_ready` are both high.

Top module: `tlb_lookup_top`

## Requirements
- R1: `req_ready` equals `!rsp_valid || rsp_ready`. A request accepted at edge N produces `rsp_valid` = 1 after edge N. While `rsp_valid` is high and `rsp_ready` is low, every response field stays unchanged and no new request is taken.
- R2: After reset the following hold: `rsp_valid` = 0, every entry is empty (so any lookup misses), the ring map reads 0x04030201, the page-table base is 0 and the refill rotation pointer is 0.
- R3: An entry hits when three things are true: its stored tag equals the lookup address shifted right by the way's page bits, its ASID is nonzero, and its ASID equals byte i (bits 8i+7:8i) of the ring map. The reported ring `rsp_ring` is the lowest such i.
- R4: Cause codes are 0 success, 1 instruction miss, 2 data miss, 3 instruction multi-hit, 4 data multi-hit, 5 instruction privilege, 6 data privilege, 7 fetch denied, 8 load denied, 9 store denied. Zero hits give a miss code and two or more hits give a multi-hit code. In both cases `rsp_paddr`, `rsp_perm`, `rsp_cache` and `rsp_ring` are 0.
- R5: On a single hit, if the entry's ring is numerically lower than `req_ring`, the cause is the privilege code for the side.
- R6: Attribute codes decode as follows. A code below 12 gives read; within such a code, bit 0 adds execute, bit 1 adds write, and bits 3:2 give `rsp_cache` (0 bypass, 1 write-back, 2 write-through). Code 13 gives read and write with `rsp_cache` = 3 (isolate). Every other code gives no rights and cache 0. `rsp_perm` is {read, write, execute} with read in bit 2.
- R7: The data side clears execute and the instruction side clears read and write before the check. `req_acc` is 0 read, 1 write, 2 execute; code 3 is never granted. A missing right gives code 9 for a data write, 8 for any other data access, and 7 on the instruction side.
- R8: On success, `rsp_paddr` is the entry's physical base ORed with the address bits below the way's page size. Each way indexes its entries with the address bits just above its page offset. With the defaults, ways 0..3 use 4 KiB pages and way 4 uses 1 MiB pages. On any fault `rsp_paddr` is 0.
- R9: The write port stores tag, base (low page bits cleared), ASID and attribute into the way `wr_way` at the entry indexed by `wr_vaddr`. The change is visible to lookups accepted from the next edge on. If a refill targets the same way in the same cycle, the write is dropped.
- R10: Each refill first increments a rotation counter that starts at 0, then writes into the way given by the counter's low 2 bits. The first refill after reset therefore goes to way 1, then 2, 3, 0, and so on. The stored ASID is the ring map byte selected by PTE bits 5:4. The attribute is PTE bits 3:0. The physical base is the PTE with the way's page bits cleared.
- R11: `rsp_pte_addr` equals (page-table base OR (`req_vaddr` >> 10)) with bits 1:0 cleared.
- R12: Writes to the ring map and to the page-table base take effect for lookups accepted from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_ring | input | 2 | Current privilege ring |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_cause | output | 4 | Fault cause code, 0 on success |
| rsp_paddr | output | 32 | Translated address |
| rsp_perm | output | 3 | {read, write, execute} after side masking |
| rsp_cache | output | 2 | Cache mode of the hit entry |
| rsp_ring | output | 2 | Ring of the hit entry |
| rsp_pte_addr | output | 32 | Page-table entry address for the request |
| wr_valid | input | 1 | Direct entry write |
| wr_way | input | WAYW | Target way of the write |
| wr_vaddr | input | 32 | Virtual address giving tag and index |
| wr_paddr | input | 32 | Physical page base |
| wr_asid | input | 8 | Entry ASID, 0 empties the entry |
| wr_attr | input | 4 | Entry attribute code |
| refill_valid | input | 1 | Refill from a page-table entry |
| refill_vaddr | input | 32 | Virtual address being refilled |
| refill_pte | input | 32 | Page-table entry contents |
| ring_map_we | input | 1 | Ring map write enable |
| ring_map_wdata | input | 32 | New ring map value |
| pt_base_we | input | 1 | Page-table base write enable |
| pt_base_wdata | input | 32 | New page-table base value |

## Verification
Every lookup result is registered once, so it is due one clock after the edge that accepts the request. The bench drives requests on the falling edge and releases them on the next falling edge. It compares all response fields there, while they are still held. The same stimulus goes to a data-side and an instruction-side instance, and each is compared with a bench model of its own side. Entry writes, refills and register writes take effect at one edge. The bench applies them in full cycles before the next request, so each lookup sees the updated state. In the back-pressure case, the bench holds `rsp_ready` low across an extra edge and checks that the held response did not move and that the queued request was taken only when ready returned.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam logic [3:0] CAUSE_OK         = 4'd0;
  localparam logic [3:0] CAUSE_I_MISS     = 4'd1;
  localparam logic [3:0] CAUSE_D_MISS     = 4'd2;
  localparam logic [3:0] CAUSE_I_MULTI    = 4'd3;
  localparam logic [3:0] CAUSE_D_MULTI    = 4'd4;
  localparam logic [3:0] CAUSE_I_PRIV     = 4'd5;
  localparam logic [3:0] CAUSE_D_PRIV     = 4'd6;
  localparam logic [3:0] CAUSE_FETCH_DENY = 4'd7;
  localparam logic [3:0] CAUSE_LOAD_DENY  = 4'd8;
  localparam logic [3:0] CAUSE_STORE_DENY = 4'd9;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  localparam logic [1:0] CM_BYPASS = 2'd0;
  localparam logic [1:0] CM_ISOL   = 2'd3;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       ex;
    logic [1:0] cmode;
  } perm_t;

  // Attribute code to rights and cache mode.
  function automatic perm_t decode_attr(input logic [3:0] a);
    perm_t p;
    p = '0;
    if (a < 4'd12) begin
      p.rd    = 1'b1;
      p.ex    = a[0];
      p.wr    = a[1];
      p.cmode = a[3:2];
    end else if (a == 4'd13) begin
      p.rd    = 1'b1;
      p.wr    = 1'b1;
      p.cmode = CM_ISOL;
    end
    return p;
  endfunction

  // Returns {found, ring}; the lowest matching byte wins.
  function automatic logic [2:0] ring_of(input logic [7:0] asid, input logic [31:0] map);
    logic [2:0] r;
    r = 3'b000;
    for (int i = 3; i >= 0; i--) begin
      if (map[i*8 +: 8] == asid) r = {1'b1, 2'(i)};
    end
    return r;
  endfunction

endpackage

// File: rtl/tlb_way.sv
module tlb_way import tlb_pkg::*; #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 4
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] lk_vaddr,
  input  logic [31:0]     ring_map,
  input  logic            we,
  input  logic [VA_W-1:0] w_vaddr,
  input  logic [VA_W-1:0] w_paddr,
  input  logic [7:0]      w_asid,
  input  logic [3:0]      w_attr,
  output logic            hit,
  output logic [1:0]      ring,
  output logic [VA_W-1:0] paddr,
  output logic [3:0]      attr
);

  localparam int IDXB = $clog2(ENTRIES);
  localparam int TAGW = VA_W - PAGE_BITS;
  localparam logic [VA_W-1:0] OFF_MASK = (VA_W'(1) << PAGE_BITS) - VA_W'(1);

  logic [TAGW-1:0] tag_q   [ENTRIES];
  logic [VA_W-1:0] base_q  [ENTRIES];
  logic [7:0]      asid_q  [ENTRIES];
  logic [3:0]      attr_q  [ENTRIES];

  logic [IDXB-1:0] lk_idx, w_idx;
  logic [TAGW-1:0] lk_tag;
  logic [2:0]      ring_hit;

  assign lk_idx = lk_vaddr[PAGE_BITS +: IDXB];
  assign lk_tag = lk_vaddr[VA_W-1:PAGE_BITS];
  assign w_idx  = w_vaddr[PAGE_BITS +: IDXB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tag_q[e]  <= '0;
        base_q[e] <= '0;
        asid_q[e] <= '0;
        attr_q[e] <= '0;
      end
    end else if (we) begin
      tag_q[w_idx]  <= w_vaddr[VA_W-1:PAGE_BITS];
      base_q[w_idx] <= w_paddr & ~OFF_MASK;
      asid_q[w_idx] <= w_asid;
      attr_q[w_idx] <= w_attr;
    end
  end

  always_comb begin
    ring_hit = ring_of(asid_q[lk_idx], ring_map);
    hit      = (tag_q[lk_idx] == lk_tag) && (asid_q[lk_idx] != 8'd0) && ring_hit[2];
    ring     = ring_hit[1:0];
    paddr    = base_q[lk_idx] | (lk_vaddr & OFF_MASK);
    attr     = attr_q[lk_idx];
  end

endmodule

// File: rtl/tlb_refill_sel.sv
module tlb_refill_sel #(
  parameter int CNT_W = 2
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic [1:0] way
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + CNT_W'(1);
  assign way    = cnt_nx[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_nx;
  end

  AST_REFILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> way == $past(way) + 2'd1); // R10

endmodule

// File: rtl/tlb_ctrl_regs.sv
module tlb_ctrl_regs #(
  parameter logic [31:0] RING_MAP_RESET = 32'h0403_0201
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ring_map_we,
  input  logic [31:0] ring_map_wdata,
  input  logic        pt_base_we,
  input  logic [31:0] pt_base_wdata,
  output logic [31:0] ring_map,
  output logic [31:0] pt_base
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_map <= RING_MAP_RESET;
      pt_base  <= '0;
    end else begin
      if (ring_map_we) ring_map <= ring_map_wdata;
      if (pt_base_we)  pt_base  <= pt_base_wdata;
    end
  end

endmodule

// File: rtl/tlb_lookup_top.sv
module tlb_lookup_top import tlb_pkg::*; #(
  parameter int NUM_WAYS = 5,
  parameter int ENTRIES  = 4,
  parameter logic [NUM_WAYS*5-1:0] WAY_PAGE_BITS = {5'd20, 5'd12, 5'd12, 5'd12, 5'd12},
  parameter bit DATA_SIDE = 1'b1,
  parameter int REFILL_CNT_W = 2,
  parameter logic [31:0] RING_MAP_RESET = 32'h0403_0201,
  localparam int WAYW = $clog2(NUM_WAYS)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_vaddr,
  input  logic [1:0]      req_acc,
  input  logic [1:0]      req_ring,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [3:0]      rsp_cause,
  output logic [31:0]     rsp_paddr,
  output logic [2:0]      rsp_perm,
  output logic [1:0]      rsp_cache,
  output logic [1:0]      rsp_ring,
  output logic [31:0]     rsp_pte_addr,
  input  logic            wr_valid,
  input  logic [WAYW-1:0] wr_way,
  input  logic [31:0]     wr_vaddr,
  input  logic [31:0]     wr_paddr,
  input  logic [7:0]      wr_asid,
  input  logic [3:0]      wr_attr,
  input  logic            refill_valid,
  input  logic [31:0]     refill_vaddr,
  input  logic [31:0]     refill_pte,
  input  logic            ring_map_we,
  input  logic [31:0]     ring_map_wdata,
  input  logic            pt_base_we,
  input  logic [31:0]     pt_base_wdata
);

  localparam int VA_W = 32;
  localparam int CNTW = $clog2(NUM_WAYS + 1);

  logic [31:0] ring_map, pt_base;
  logic [1:0]  rf_way;
  logic [7:0]  rf_asid;

  logic [NUM_WAYS-1:0] hit_vec;
  logic [1:0]          way_ring [NUM_WAYS];
  logic [VA_W-1:0]     way_pa   [NUM_WAYS];
  logic [3:0]          way_attr [NUM_WAYS];

  tlb_ctrl_regs #(.RING_MAP_RESET(RING_MAP_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ring_map_we(ring_map_we), .ring_map_wdata(ring_map_wdata),
    .pt_base_we(pt_base_we), .pt_base_wdata(pt_base_wdata),
    .ring_map(ring_map), .pt_base(pt_base)
  );

  tlb_refill_sel #(.CNT_W(REFILL_CNT_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(refill_valid), .way(rf_way)
  );

  assign rf_asid = ring_map[refill_pte[5:4]*8 +: 8];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    localparam int PB = int'(WAY_PAGE_BITS[w*5 +: 5]);
    logic            rf_sel, we;
    logic [VA_W-1:0] w_va, w_pa;
    logic [7:0]      w_asid;
    logic [3:0]      w_attr;

    assign rf_sel = refill_valid && (int'(rf_way) == w);
    assign we     = rf_sel || (wr_valid && (int'(wr_way) == w));
    assign w_va   = rf_sel ? refill_vaddr     : wr_vaddr;
    assign w_pa   = rf_sel ? refill_pte       : wr_paddr;
    assign w_asid = rf_sel ? rf_asid          : wr_asid;
    assign w_attr = rf_sel ? refill_pte[3:0]  : wr_attr;

    tlb_way #(.VA_W(VA_W), .PAGE_BITS(PB), .ENTRIES(ENTRIES)) u_way (
      .clk(clk), .rst_n(rst_n),
      .lk_vaddr(req_vaddr), .ring_map(ring_map),
      .we(we), .w_vaddr(w_va), .w_paddr(w_pa), .w_asid(w_asid), .w_attr(w_attr),
      .hit(hit_vec[w]), .ring(way_ring[w]), .paddr(way_pa[w]), .attr(way_attr[w])
    );
  end

  // Resolution of the per-way results into one answer.
  logic [CNTW-1:0] nhits;
  logic [1:0]      sel_ring;
  logic [VA_W-1:0] sel_pa;
  logic [3:0]      sel_attr;
  perm_t           perm;
  logic            granted;
  logic [3:0]      deny_cause;
  logic [3:0]      n_cause;
  logic [31:0]     n_paddr;
  logic [2:0]      n_perm;
  logic [1:0]      n_cache, n_ring;
  logic [31:0]     n_pte;

  always_comb begin
    nhits    = CNTW'($countones(hit_vec));
    sel_ring = '0;
    sel_pa   = '0;
    sel_attr = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hit_vec[w]) begin
        sel_ring = way_ring[w];
        sel_pa   = way_pa[w];
        sel_attr = way_attr[w];
      end
    end

    perm = decode_attr(sel_attr);
    if (DATA_SIDE) perm.ex = 1'b0;
    else begin
      perm.rd = 1'b0;
      perm.wr = 1'b0;
    end

    case (req_acc)
      ACC_RD:  granted = perm.rd;
      ACC_WR:  granted = perm.wr;
      ACC_EX:  granted = perm.ex;
      default: granted = 1'b0;
    endcase

    if (DATA_SIDE) deny_cause = (req_acc == ACC_WR) ? CAUSE_STORE_DENY : CAUSE_LOAD_DENY;
    else           deny_cause = CAUSE_FETCH_DENY;

    n_paddr = '0;
    n_perm  = '0;
    n_cache = CM_BYPASS;
    n_ring  = '0;
    if (nhits == '0) begin
      n_cause = DATA_SIDE ? CAUSE_D_MISS : CAUSE_I_MISS;
    end else if (nhits > CNTW'(1)) begin
      n_cause = DATA_SIDE ? CAUSE_D_MULTI : CAUSE_I_MULTI;
    end else begin
      n_perm  = {perm.rd, perm.wr, perm.ex};
      n_cache = perm.cmode;
      n_ring  = sel_ring;
      if (sel_ring < req_ring) n_cause = DATA_SIDE ? CAUSE_D_PRIV : CAUSE_I_PRIV;
      else if (!granted)       n_cause = deny_cause;
      else begin
        n_cause = CAUSE_OK;
        n_paddr = sel_pa;
      end
    end

    n_pte = (pt_base | (req_vaddr >> 10)) & ~32'h3;
  end

  // Response register with valid/ready hold.
  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_cause    <= '0;
      rsp_paddr    <= '0;
      rsp_perm     <= '0;
      rsp_cache    <= '0;
      rsp_ring     <= '0;
      rsp_pte_addr <= '0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_cause    <= n_cause;
      rsp_paddr    <= n_paddr;
      rsp_perm     <= n_perm;
      rsp_cache    <= n_cache;
      rsp_ring     <= n_ring;
      rsp_pte_addr <= n_pte;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_cause) && $stable(rsp_paddr) && $stable(rsp_pte_addr)); // R1

  AST_MISS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (hit_vec == '0) |=> (rsp_cause == CAUSE_D_MISS || rsp_cause == CAUSE_I_MISS) && rsp_paddr == '0); // R4

  AST_MULTI_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ($countones(hit_vec) > 1) |=> (rsp_cause == CAUSE_D_MULTI || rsp_cause == CAUSE_I_MULTI)); // R4

  AST_OK_HAS_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cause == CAUSE_OK |-> rsp_perm != 3'b000); // R7

  AST_ISOLATE_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cache == CM_ISOL |-> !rsp_perm[0]); // R6

endmodule

// File: tb/tb_tlb_lookup_top.sv
module tb_tlb_lookup_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, rsp_ready = 1;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_acc = 0, req_ring = 0;
  logic        wr_valid = 0;
  logic [2:0]  wr_way = 0;
  logic [31:0] wr_vaddr = 0, wr_paddr = 0;
  logic [7:0]  wr_asid = 0;
  logic [3:0]  wr_attr = 0;
  logic        refill_valid = 0;
  logic [31:0] refill_vaddr = 0, refill_pte = 0;
  logic        ring_map_we = 0, pt_base_we = 0;
  logic [31:0] ring_map_wdata = 0, pt_base_wdata = 0;

  logic        d_req_ready, d_rsp_valid, i_req_ready, i_rsp_valid;
  logic [3:0]  d_cause, i_cause;
  logic [31:0] d_paddr, i_paddr, d_pte, i_pte;
  logic [2:0]  d_perm, i_perm;
  logic [1:0]  d_cache, i_cache, d_ring, i_ring;

  tlb_lookup_top #(.DATA_SIDE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(d_req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .req_ring(req_ring),
    .rsp_valid(d_rsp_valid), .rsp_ready(rsp_ready), .rsp_cause(d_cause),
    .rsp_paddr(d_paddr), .rsp_perm(d_perm), .rsp_cache(d_cache), .rsp_ring(d_ring),
    .rsp_pte_addr(d_pte), .wr_valid(wr_valid), .wr_way(wr_way), .wr_vaddr(wr_vaddr),
    .wr_paddr(wr_paddr), .wr_asid(wr_asid), .wr_attr(wr_attr),
    .refill_valid(refill_valid), .refill_vaddr(refill_vaddr), .refill_pte(refill_pte),
    .ring_map_we(ring_map_we), .ring_map_wdata(ring_map_wdata),
    .pt_base_we(pt_base_we), .pt_base_wdata(pt_base_wdata));

  tlb_lookup_top #(.DATA_SIDE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(i_req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .req_ring(req_ring),
    .rsp_valid(i_rsp_valid), .rsp_ready(rsp_ready), .rsp_cause(i_cause),
    .rsp_paddr(i_paddr), .rsp_perm(i_perm), .rsp_cache(i_cache), .rsp_ring(i_ring),
    .rsp_pte_addr(i_pte), .wr_valid(wr_valid), .wr_way(wr_way), .wr_vaddr(wr_vaddr),
    .wr_paddr(wr_paddr), .wr_asid(wr_asid), .wr_attr(wr_attr),
    .refill_valid(refill_valid), .refill_vaddr(refill_vaddr), .refill_pte(refill_pte),
    .ring_map_we(ring_map_we), .ring_map_wdata(ring_map_wdata),
    .pt_base_we(pt_base_we), .pt_base_wdata(pt_base_wdata));

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Bench model of the stored state.
  logic [31:0] m_tag  [5][4];
  logic [31:0] m_base [5][4];
  logic [7:0]  m_asid [5][4];
  logic [3:0]  m_attr [5][4];
  logic [31:0] m_map;
  logic [31:0] m_ptb;
  int          m_cnt;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic int pbits(input int w);
    return (w == 4) ? 20 : 12;
  endfunction

  function automatic void model_put(input int w, input logic [31:0] va, input logic [31:0] pa,
                                    input logic [7:0] asid, input logic [3:0] attr);
    int pb;
    int e;
    pb = pbits(w);
    e  = int'((va >> pb) & 32'h3);
    m_tag[w][e]  = va >> pb;
    m_base[w][e] = pa & ~((32'd1 << pb) - 32'd1);
    m_asid[w][e] = asid;
    m_attr[w][e] = attr;
  endfunction

  function automatic void model_lookup(input bit dside, input logic [31:0] va, input logic [1:0] acc,
      input logic [1:0] cr, output logic [3:0] cause, output logic [31:0] pa,
      output logic [2:0] perm, output logic [1:0] cm, output logic [1:0] rg);
    int n;
    logic [1:0] hr;
    logic [31:0] hpa;
    logic [3:0] ha;
    bit r, wr, x, g;
    logic [1:0] c;
    n = 0; hr = 0; hpa = 0; ha = 0;
    for (int w = 0; w < 5; w++) begin
      int pb;
      int e;
      int rr;
      pb = pbits(w);
      e  = int'((va >> pb) & 32'h3);
      rr = -1;
      for (int i = 0; i < 4; i++)
        if (rr < 0 && m_map[i*8 +: 8] == m_asid[w][e]) rr = i;
      if (m_tag[w][e] == (va >> pb) && m_asid[w][e] != 0 && rr >= 0) begin
        n++;
        hr  = 2'(rr);
        hpa = m_base[w][e] | (va & ((32'd1 << pb) - 32'd1));
        ha  = m_attr[w][e];
      end
    end
    pa = 0; perm = 0; cm = 0; rg = 0;
    if (n == 0) begin
      cause = dside ? 4'd2 : 4'd1;
      return;
    end
    if (n > 1) begin
      cause = dside ? 4'd4 : 4'd3;
      return;
    end
    r = 0; wr = 0; x = 0; c = 0;
    if (ha < 12) begin r = 1; x = ha[0]; wr = ha[1]; c = ha[3:2]; end
    else if (ha == 13) begin r = 1; wr = 1; c = 3; end
    if (dside) x = 0; else begin r = 0; wr = 0; end
    perm = {r, wr, x}; cm = c; rg = hr;
    g = (acc == 0) ? r : (acc == 1) ? wr : (acc == 2) ? x : 1'b0;
    if (hr < cr) cause = dside ? 4'd6 : 4'd5;
    else if (!g) cause = dside ? ((acc == 1) ? 4'd9 : 4'd8) : 4'd7;
    else begin cause = 4'd0; pa = hpa; end
  endfunction

  task automatic do_write(input int w, input logic [31:0] va, input logic [31:0] pa,
                          input logic [7:0] asid, input logic [3:0] attr);
    wr_valid = 1; wr_way = 3'(w); wr_vaddr = va; wr_paddr = pa; wr_asid = asid; wr_attr = attr;
    @(posedge clk); @(negedge clk);
    wr_valid = 0;
    model_put(w, va, pa, asid, attr);
  endtask

  task automatic do_refill(input logic [31:0] va, input logic [31:0] pte, input bit with_wr,
                           input int w, input logic [31:0] wva);
    int rw;
    rw = (m_cnt + 1) & 3;
    refill_valid = 1; refill_vaddr = va; refill_pte = pte;
    if (with_wr) begin
      wr_valid = 1; wr_way = 3'(w); wr_vaddr = wva; wr_paddr = 32'h1111_1000; wr_asid = 8'd1; wr_attr = 4'd4;
    end
    @(posedge clk); @(negedge clk);
    refill_valid = 0; wr_valid = 0;
    if (with_wr && w != rw) model_put(w, wva, 32'h1111_1000, 8'd1, 4'd4);
    model_put(rw, va, pte, m_map[pte[5:4]*8 +: 8], pte[3:0]);
    m_cnt = rw;
  endtask

  task automatic do_lookup(input string rq, input logic [31:0] va, input logic [1:0] acc,
                           input logic [1:0] cr, input int want);
    logic [3:0] ec; logic [31:0] ep; logic [2:0] eperm; logic [1:0] ecm, erg;
    req_valid = 1; req_vaddr = va; req_acc = acc; req_ring = cr;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk(rq, "rsp_valid", 32'(d_rsp_valid), 32'd1);
    model_lookup(1'b1, va, acc, cr, ec, ep, eperm, ecm, erg);
    chk(rq, "d cause", 32'(d_cause), 32'(ec));
    chk(rq, "d paddr", d_paddr, ep);
    chk(rq, "d perm",  32'(d_perm), 32'(eperm));
    chk(rq, "d cache", 32'(d_cache), 32'(ecm));
    chk(rq, "d ring",  32'(d_ring), 32'(erg));
    if (want >= 0) chk(rq, "d cause literal", 32'(d_cause), 32'(want));
    model_lookup(1'b0, va, acc, cr, ec, ep, eperm, ecm, erg);
    chk(rq, "i cause", 32'(i_cause), 32'(ec));
    chk(rq, "i paddr", i_paddr, ep);
    chk(rq, "i perm",  32'(i_perm), 32'(eperm));
    chk(rq, "i cache", 32'(i_cache), 32'(ecm));
    chk(rq, "i ring",  32'(i_ring), 32'(erg));
    chk("R11", "pte addr", d_pte, (m_ptb | (va >> 10)) & ~32'h3);
  endtask

  function automatic logic [31:0] rva();
    logic [31:0] v;
    v = $urandom;
    v[31:22] = '0;
    v[19:14] = '0;
    return v;
  endfunction

  function automatic logic [7:0] pick_asid();
    case ($urandom_range(0, 5))
      0: return 8'd0;
      1: return 8'd1;
      2: return 8'd2;
      3: return 8'd3;
      4: return 8'd4;
      default: return 8'h55;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] hold_c;
    logic [31:0] hold_p;
    void'($urandom(32'd20240611));
    for (int w = 0; w < 5; w++)
      for (int e = 0; e < 4; e++) begin
        m_tag[w][e] = 0; m_base[w][e] = 0; m_asid[w][e] = 0; m_attr[w][e] = 0;
      end
    m_map = 32'h0403_0201; m_ptb = 0; m_cnt = 0;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset state
    chk("R2", "rsp_valid after reset", 32'(d_rsp_valid), 32'd0);
    chk("R2", "req_ready after reset", 32'(d_req_ready), 32'd1);
    do_lookup("R2", 32'h0000_1234, 2'd0, 2'd0, 2);
    chk("R2", "pte with zero base", d_pte, 32'h0000_0004);

    // R3 ring from default map: asid 4 is byte 3
    do_write(0, 32'h0000_5000, 32'hABCD_E000, 8'd4, 4'h3);
    do_lookup("R3", 32'h0000_5ABC, 2'd0, 2'd0, 0);
    chk("R3", "ring of asid 4", 32'(d_ring), 32'd3);
    chk("R8", "paddr 4K", d_paddr, 32'hABCD_EABC);

    // R5 privilege
    do_write(2, 32'h0000_9000, 32'h2000_0000, 8'd1, 4'h6);
    do_lookup("R5", 32'h0000_9010, 2'd0, 2'd1, 6);
    chk("R5", "instr side priv", 32'(i_cause), 32'd5);
    do_lookup("R5", 32'h0000_9010, 2'd1, 2'd0, 0);

    // R4 multi-hit and misses
    do_write(1, 32'h0000_5000, 32'h3000_0000, 8'd2, 4'h4);
    do_lookup("R4", 32'h0000_5004, 2'd0, 2'd0, 4);
    chk("R4", "instr multi", 32'(i_cause), 32'd3);
    do_write(3, 32'h0000_6000, 32'h3000_0000, 8'h77, 4'h4);
    do_lookup("R4", 32'h0000_6004, 2'd0, 2'd0, 2);

    // R6 / R7 attribute decode and side masks
    do_write(3, 32'h0000_3000, 32'h4000_0000, 8'd1, 4'd13);
    do_lookup("R6", 32'h0000_3008, 2'd1, 2'd0, 0);
    chk("R6", "isolate cache", 32'(d_cache), 32'd3);
    chk("R6", "isolate perm", 32'(d_perm), 32'b110);
    do_lookup("R7", 32'h0000_3008, 2'd2, 2'd0, 8);
    chk("R7", "instr fetch deny", 32'(i_cause), 32'd7);
    do_write(0, 32'h0000_7000, 32'h4000_0000, 8'd1, 4'd15);
    do_lookup("R6", 32'h0000_7000, 2'd0, 2'd0, 8);
    do_lookup("R7", 32'h0000_7000, 2'd1, 2'd0, 9);
    do_write(0, 32'h0000_2000, 32'h4400_0000, 8'd1, 4'd9);
    do_lookup("R7", 32'h0000_2000, 2'd2, 2'd0, 8);
    chk("R7", "instr exec ok", 32'(i_cause), 32'd0);
    chk("R6", "write-through code", 32'(d_cache), 32'd2);
    do_lookup("R7", 32'h0000_2000, 2'd3, 2'd0, 8);

    // R8 large page way
    do_write(4, 32'h0030_0000, 32'h1230_0000, 8'd1, 4'h4);
    do_lookup("R8", 32'h0034_5678, 2'd0, 2'd0, 0);
    chk("R8", "paddr 1M", d_paddr, 32'h1234_5678);
    chk("R6", "write-back code", 32'(d_cache), 32'd1);

    // R10 refill rotation: first goes to way 1 (replaces 0x5000 there)
    do_refill(32'h0000_D000, 32'h4567_8014, 1'b0, 0, 0);
    do_lookup("R10", 32'h0000_D123, 2'd0, 2'd0, 0);
    chk("R10", "refill ring from pte", 32'(d_ring), 32'd1);
    chk("R10", "refill paddr", d_paddr, 32'h4567_8123);
    do_lookup("R10", 32'h0000_5004, 2'd0, 2'd0, 0);
    do_refill(32'h0000_D000, 32'h4567_8014, 1'b0, 0, 0);
    do_lookup("R10", 32'h0000_D123, 2'd0, 2'd0, 4);

    // R9 write dropped when refill hits same way (third refill -> way 3)
    do_refill(32'h0000_E000, 32'h5000_0004, 1'b1, 3, 32'h0000_1000);
    do_lookup("R9", 32'h0000_1000, 2'd0, 2'd0, 2);
    do_lookup("R9", 32'h0000_E000, 2'd0, 2'd0, 0);
    do_refill(32'h0000_8000, 32'h5100_0004, 1'b1, 2, 32'h0000_1000);
    do_lookup("R9", 32'h0000_1000, 2'd0, 2'd0, 0);
    do_lookup("R10", 32'h0000_8000, 2'd0, 2'd0, 0);

    // R11 / R12 register writes
    pt_base_we = 1; pt_base_wdata = 32'h8000_0000;
    @(posedge clk); @(negedge clk); pt_base_we = 0; m_ptb = 32'h8000_0000;
    do_lookup("R11", 32'h0012_3456, 2'd0, 2'd0, -1);
    chk("R11", "pte with base", d_pte, 32'h8000_048C);
    ring_map_we = 1; ring_map_wdata = 32'h0707_0701;
    @(posedge clk); @(negedge clk); ring_map_we = 0; m_map = 32'h0707_0701;
    do_write(0, 32'h0000_F000, 32'h6000_0000, 8'd7, 4'h4);
    do_lookup("R12", 32'h0000_F000, 2'd0, 2'd0, 0);
    chk("R12", "lowest duplicate ring", 32'(d_ring), 32'd1);
    do_lookup("R12", 32'h0000_5ABC, 2'd0, 2'd0, 2);
    ring_map_we = 1; ring_map_wdata = 32'h0403_0201;
    @(posedge clk); @(negedge clk); ring_map_we = 0; m_map = 32'h0403_0201;

    // R1 back-pressure
    rsp_ready = 0;
    req_valid = 1; req_vaddr = 32'h0034_5678; req_acc = 0; req_ring = 0;
    @(posedge clk); @(negedge clk);
    chk("R1", "valid one cycle after accept", 32'(d_rsp_valid), 32'd1);
    chk("R1", "ready low while held", 32'(d_req_ready), 32'd0);
    hold_c = d_cause; hold_p = d_paddr;
    req_vaddr = 32'h0000_E123;
    @(posedge clk); @(negedge clk);
    chk("R1", "held cause", 32'(d_cause), 32'(hold_c));
    chk("R1", "held paddr", d_paddr, hold_p);
    chk("R1", "held paddr value", d_paddr, 32'h1234_5678);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R1", "queued request served", d_paddr, 32'h5000_0123);
    @(posedge clk); @(negedge clk);
    chk("R1", "valid drops when consumed", 32'(d_rsp_valid), 32'd0);

    // Random mix
    for (int it = 0; it < 500; it++) begin
      int unsigned sel;
      sel = $urandom_range(0, 9);
      if (sel < 3) do_write(int'($urandom_range(0, 4)), rva(), $urandom, pick_asid(), 4'($urandom));
      else if (sel == 3) do_refill(rva(), $urandom, 1'b0, 0, 0);
      else do_lookup("R6", rva(), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), -1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule